// File: doc/BRIEF.md
# Prescaled BCD Time-of-Day and Calendar Counter

The block turns a clock-enable pulse stream from a slow timing source into a one-second tick and keeps a packed-BCD time of day and calendar date. The tick comes from two dividers in series. The first is a fast 7-bit stage. The second is a 15-bit stage that counts only when the first stage wraps. Each stage has a programmable reload value. One tick therefore takes (first reload + 1) × (second reload + 1) enables.

On every tick the seconds advance, and carries move through minutes, hours, day of month, month and a two-digit year. The year covers 2000 to 2099, and leap years are taken into account. A weekday counter moves forward at each day change.

Software sets the calendar by raising the init input. While init is high, the counters are frozen and whole time and date words can be loaded. When init falls, both divider stages begin a full period again. Loading all-zero words gives the reset calendar value.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, time_o and date_o are all zeros and tick_o is low.
- R2: tick_o is asserted for one enabled cycle out of every (async_rld_i+1)*(sync_rld_i+1) cycles in which rtc_en_i is high. Cycles with rtc_en_i low do not advance either divider.
- R3: The time word holds BCD seconds in bits [6:0], minutes in [14:8] and hours in [21:16]. Bits 7 and 15 read as zero. On a tick, seconds go from 59 to 00 and carry into minutes, and minutes go from 59 to 00 and carry into hours.
- R4: On a tick at 23:59:59 the time becomes 00:00:00 and the date advances by one day. On any other tick, date_o does not change.
- R5: The date word holds BCD day in [5:0], month in [12:8], weekday in [15:13] and year in [23:16]. The last day of a month is 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the year is divisible by 4 (00 included) and 28 otherwise. For every other month it is 31. After the last day comes day 01 of the next month.
- R6: After day 31 of month 12 comes day 01 of month 01 with the year incremented. Year 99 wraps to 00.
- R7: The weekday advances by one at each day change, and 7 wraps to 1.
- R8: time_wr_i and date_wr_i load time_i and date_i only while init_i is high. A write with init_i low has no effect.
- R9: While init_i is high there is no tick and the time and date hold, apart from loads. After init_i falls, the first tick comes after a full (async_rld_i+1)*(sync_rld_i+1) enables.
- R10: An all-zero time and date load is accepted. From that state the time counts up normally from 00:00:00 and the date stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtc_en_i | input | 1 | One-cycle enable from the timing source |
| init_i | input | 1 | Init mode: freezes the counters and allows loads |
| async_rld_i | input | 7 | Reload value of the first divider stage |
| sync_rld_i | input | 15 | Reload value of the second divider stage |
| time_wr_i | input | 1 | Load strobe for the time word |
| time_i | input | 22 | Packed BCD time to load |
| date_wr_i | input | 1 | Load strobe for the date word |
| date_i | input | 24 | Packed BCD date to load |
| tick_o | output | 1 | One-second tick, high in the cycle that advances the calendar |
| time_o | output | 22 | Packed BCD time of day |
| date_o | output | 24 | Packed BCD date |

## Verification
The hardest cases to reach are the long carry chains: the leap-day decision in February, year 99 rolling into 00, and the weekday wrapping. At a real prescale these take years of simulated ticks. The bench reaches them by loading a time of 23:59:59 and a date just before each boundary while in init mode, then setting both reloads to zero so that every enabled cycle is a tick. A single cycle then drives the full carry chain. The restart of both dividers at init exit is checked by leaving init partway through a divider period and counting the cycles to the first tick.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int ASYNC_W = 7;
  localparam int SYNC_W  = 15;
  localparam int TIME_W  = 22;
  localparam int DATE_W  = 24;
  localparam logic [TIME_W-1:0] TIME_MASK = 22'h3F7F7F;
  localparam logic [DATE_W-1:0] DATE_MASK = 24'hFFFF3F;

  function automatic logic [7:0] inc8(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] inc7(input logic [6:0] v);
    return (v[3:0] >= 4'd9) ? {v[6:4] + 3'd1, 4'd0} : {v[6:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] inc6(input logic [5:0] v);
    return (v[3:0] >= 4'd9) ? {v[5:4] + 2'd1, 4'd0} : {v[5:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [4:0] inc5(input logic [4:0] v);
    return (v[3:0] >= 4'd9) ? {v[4] + 1'b1, 4'd0} : {v[4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4 on a BCD pair: even tens -> 0/4/8, odd tens -> 2/6
  function automatic logic leap_yr(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      return leap_yr(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         hold_i,
  input  logic [W-1:0] reload_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && !hold_i && (cnt_q >= reload_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_time.sv
module cal_time
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  input  logic              tick_i,
  output logic [TIME_W-1:0] time_o,
  output logic              day_o
);
  logic [TIME_W-1:0] time_q;
  logic [6:0] sec, mnt, sec_n, mnt_n;
  logic [5:0] hr, hr_n;
  logic sec_wrap, mnt_wrap, hr_wrap;

  assign sec = time_q[6:0];
  assign mnt = time_q[14:8];
  assign hr  = time_q[21:16];

  assign sec_wrap = sec >= 7'h59;
  assign mnt_wrap = mnt >= 7'h59;
  assign hr_wrap  = hr  >= 6'h23;
  assign day_o    = tick_i && sec_wrap && mnt_wrap && hr_wrap;

  always_comb begin
    sec_n = sec_wrap ? 7'h00 : inc7(sec);
    mnt_n = mnt;
    hr_n  = hr;
    if (sec_wrap) begin
      mnt_n = mnt_wrap ? 7'h00 : inc7(mnt);
      if (mnt_wrap) hr_n = hr_wrap ? 6'h00 : inc6(hr);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= '0;
    else if (load_i) time_q <= load_val_i & TIME_MASK;
    else if (tick_i) time_q <= {hr_n, 1'b0, mnt_n, 1'b0, sec_n};
  end

  assign time_o = time_q;
endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATE_W-1:0] load_val_i,
  input  logic              day_i,
  output logic [DATE_W-1:0] date_o
);
  logic [DATE_W-1:0] date_q;
  logic [5:0] day, day_n;
  logic [4:0] mon, mon_n;
  logic [2:0] wd, wd_n;
  logic [7:0] yr, yr_n;
  logic month_end, year_end;

  assign day = date_q[5:0];
  assign mon = date_q[12:8];
  assign wd  = date_q[15:13];
  assign yr  = date_q[23:16];

  assign month_end = day >= last_day(mon, yr);
  assign year_end  = mon >= 5'h12;

  always_comb begin
    day_n = month_end ? 6'h01 : inc6(day);
    mon_n = mon;
    yr_n  = yr;
    wd_n  = (wd >= 3'd7) ? 3'd1 : wd + 3'd1;
    if (month_end) begin
      mon_n = year_end ? 5'h01 : inc5(mon);
      if (year_end) yr_n = (yr >= 8'h99) ? 8'h00 : inc8(yr);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     date_q <= '0;
    else if (load_i) date_q <= load_val_i & DATE_MASK;
    else if (day_i)  date_q <= {yr_n, wd_n, mon_n, 2'b00, day_n};
  end

  assign date_o = date_q;
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rtc_en_i,
  input  logic               init_i,
  input  logic [ASYNC_W-1:0] async_rld_i,
  input  logic [SYNC_W-1:0]  sync_rld_i,
  input  logic               time_wr_i,
  input  logic [TIME_W-1:0]  time_i,
  input  logic               date_wr_i,
  input  logic [DATE_W-1:0]  date_i,
  output logic               tick_o,
  output logic [TIME_W-1:0]  time_o,
  output logic [DATE_W-1:0]  date_o
);
  logic async_wrap, sync_wrap, day_step;

  cal_divider #(.W(ASYNC_W)) u_async (
    .clk_i, .rst_ni, .en_i(rtc_en_i), .hold_i(init_i),
    .reload_i(async_rld_i), .wrap_o(async_wrap)
  );

  cal_divider #(.W(SYNC_W)) u_sync (
    .clk_i, .rst_ni, .en_i(async_wrap), .hold_i(init_i),
    .reload_i(sync_rld_i), .wrap_o(sync_wrap)
  );

  assign tick_o = sync_wrap;

  cal_time u_time (
    .clk_i, .rst_ni, .load_i(init_i && time_wr_i), .load_val_i(time_i),
    .tick_i(sync_wrap), .time_o, .day_o(day_step)
  );

  cal_date u_date (
    .clk_i, .rst_ni, .load_i(init_i && date_wr_i), .load_val_i(date_i),
    .day_i(day_step), .date_o
  );
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        init_i,
  input logic        time_wr_i,
  input logic        tick_o,
  input logic [21:0] time_o,
  input logic [23:0] date_o
);
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !init_i) |=> ($stable(time_o) && $stable(date_o))); // R8
  AST_INIT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !time_wr_i) |=> $stable(time_o)); // R9
  AST_SEC_ROLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && time_o[6:0] == 7'h59) |=> (time_o[6:0] == 7'h00)); // R3
  AST_DATE_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && time_o != 22'h235959) |=> $stable(date_o)); // R4
  AST_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && time_o == 22'h235959) |=> (time_o == 22'h0)); // R4
  AST_WDAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && time_o == 22'h235959 && date_o[15:13] == 3'd7) |=> (date_o[15:13] == 3'd1)); // R7
  AST_YEAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && time_o == 22'h235959 && date_o[23:16] == 8'h99 && date_o[12:8] == 5'h12
     && date_o[5:0] == 6'h31)
    |=> (date_o[23:16] == 8'h00 && date_o[12:8] == 5'h01 && date_o[5:0] == 6'h01)); // R6
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .time_wr_i(time_wr_i),
  .tick_o(tick_o), .time_o(time_o), .date_o(date_o)
);

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, init = 1'b0, twr = 1'b0, dwr = 1'b0;
  logic [6:0]  a_rl = '0;
  logic [14:0] s_rl = '0;
  logic [21:0] tw = '0;
  logic [23:0] dw = '0;
  logic tick;
  logic [21:0] time_w;
  logic [23:0] date_w;

  int n_chk = 0, n_bad = 0;
  int m_a = 0, m_s = 0;
  int sec = 0, mnt = 0, hr = 0, day = 0, mon = 0, yr = 0, wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar u0 (
    .clk_i(clk), .rst_ni(rst_n), .rtc_en_i(en), .init_i(init),
    .async_rld_i(a_rl), .sync_rld_i(s_rl), .time_wr_i(twr), .time_i(tw),
    .date_wr_i(dwr), .date_i(dw), .tick_o(tick), .time_o(time_w), .date_o(date_w)
  );

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic logic [21:0] exp_time();
    return {i2b(hr), i2b(mnt), i2b(sec)} & 22'h3F7F7F;
  endfunction
  function automatic logic [23:0] exp_date();
    logic [23:0] d;
    d = {i2b(yr), 16'h0} | (24'(wd) << 13) | (24'(i2b(mon)) << 8) | 24'(i2b(day));
    return d;
  endfunction

  task automatic advance();
    if (sec >= 59) begin
      sec = 0;
      if (mnt >= 59) begin
        mnt = 0;
        if (hr >= 23) begin
          hr = 0;
          if (day >= mlen(mon, yr)) begin
            day = 1;
            if (mon >= 12) begin mon = 1; yr = (yr >= 99) ? 0 : yr + 1; end
            else mon = mon + 1;
          end else day = day + 1;
          wd = (wd >= 7) ? 1 : wd + 1;
        end else hr = hr + 1;
      end else mnt = mnt + 1;
    end else sec = sec + 1;
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_s = 0; sec = 0; mnt = 0; hr = 0; day = 0; mon = 0; yr = 0; wd = 0;
    end else if (init) begin
      m_a = 0; m_s = 0;
      if (twr) begin sec = b2i({1'b0, tw[6:0]}); mnt = b2i({1'b0, tw[14:8]}); hr = b2i({2'b0, tw[21:16]}); end
      if (dwr) begin
        day = b2i({2'b0, dw[5:0]}); mon = b2i({3'b0, dw[12:8]});
        wd = int'(dw[15:13]); yr = b2i(dw[23:16]);
      end
    end else if (en) begin
      if (m_a >= int'(a_rl)) begin
        m_a = 0;
        if (m_s >= int'(s_rl)) begin m_s = 0; advance(); end
        else m_s = m_s + 1;
      end else m_a = m_a + 1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_tick;
      exp_tick = en && !init && (m_a >= int'(a_rl)) && (m_s >= int'(s_rl));
      n_chk++;
      if (tick !== exp_tick) begin
        n_bad++; $display("FAIL R2 tick: actual %b expected %b", tick, exp_tick);
      end else if (time_w !== exp_time()) begin
        n_bad++; $display("FAIL R3 R4 time: actual %h expected %h", time_w, exp_time());
      end else if (date_w !== exp_date()) begin
        n_bad++; $display("FAIL R5 R6 R7 date: actual %h expected %h", date_w, exp_date());
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++; $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // load in init, leave init, then one more cycle (one tick when reloads are 0)
  task automatic load_run(input logic [21:0] t, input logic [23:0] d);
    #1; init = 1'b1; twr = 1'b1; dwr = 1'b1; tw = t; dw = d;
    @(negedge clk); #1; twr = 1'b0; dwr = 1'b0; init = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    logic [21:0] held_t;
    logic [23:0] held_d;
    cyc(3);
    check("R1 time", 32'(time_w), 32'h0);
    check("R1 date", 32'(date_w), 32'h0);
    check("R1 tick", 32'(tick), 32'h0);
    #1; rst_n = 1'b1;

    // R2: 12 enables per tick, enable every other cycle
    a_rl = 7'd2; s_rl = 15'd3; init = 1'b1;
    cyc(1); #1; init = 1'b0;
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      en = (i % 2 == 0);
      @(negedge clk);
      if (tick) cnt++;
      #1;
    end
    check("R2 tick count", 32'(cnt), 32'd8);

    // fast ticks for calendar carries
    en = 1'b1; a_rl = '0; s_rl = '0;
    load_run(22'h123459, 24'h250315);
    check("R3 sec roll", 32'(time_w), 32'h123500);
    load_run(22'h125959, 24'h250315);
    check("R3 min roll", 32'(time_w), 32'h130000);
    check("R4 date unchanged", 32'(date_w), 32'h250315);
    load_run(22'h235959, 24'h24E228);
    check("R5 leap feb 29", 32'(date_w), 32'h242229);
    check("R7 wday 7 to 1", 32'(date_w[15:13]), 32'd1);
    check("R4 midnight", 32'(time_w), 32'h0);
    load_run(22'h235959, 24'h242229);
    check("R5 feb 29 to mar", 32'(date_w), 32'h244301);
    load_run(22'h235959, 24'h236228);
    check("R5 non-leap feb", 32'(date_w), 32'h238301);
    load_run(22'h235959, 24'h00A228);
    check("R5 year 00 leap", 32'(date_w), 32'h00C229);
    load_run(22'h235959, 24'h254430);
    check("R5 30-day month", 32'(date_w), 32'h256501);
    load_run(22'h235959, 24'h99F231);
    check("R6 year wrap", 32'(date_w), 32'h002101);
    check("R6 time", 32'(time_w), 32'h0);

    // R8: write outside init is ignored
    #1; en = 1'b0;
    cyc(1);
    held_t = time_w; held_d = date_w;
    #1; twr = 1'b1; dwr = 1'b1; tw = 22'h112233; dw = 24'h771111;
    cyc(1); #1; twr = 1'b0; dwr = 1'b0;
    cyc(1);
    check("R8 time ignored", 32'(time_w), 32'(held_t));
    check("R8 date ignored", 32'(date_w), 32'(held_d));

    // R9: freeze and divider restart
    #1; en = 1'b1; a_rl = 7'd1; s_rl = 15'd1;
    cyc(2);
    #1; init = 1'b1;
    held_t = time_w;
    cyc(10);
    check("R9 frozen", 32'(time_w), 32'(held_t));
    #1; init = 1'b0;
    cnt = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (tick && cnt == 0) cnt = i;
    end
    check("R9 restart", 32'(cnt), 32'd3);

    // R10: all-zero load
    #1; a_rl = '0; s_rl = '0;
    load_run(22'h0, 24'h0);
    cyc(60);
    check("R10 zero load time", 32'(time_w), 32'h000101);
    check("R10 zero load date", 32'(date_w), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule